// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Program Engine

This block sits behind the serial command decoder of a small non-volatile byte memory. When the decoder has parsed a write instruction and its address, it pulses `start_vld` with the nine-bit byte address. Each data byte that follows arrives as a `byte_vld` pulse and is collected in a four-slot page buffer. Only the low two address bits step from byte to byte, so a page never crosses its aligned four-byte boundary. A per-slot valid mask records which slots actually received data.

When chip select rises, the decoder pulses `cs_rise`. With it, `cs_rise_bnd` says whether the rise fell exactly after the last bit of a complete byte. A program cycle begins only if four things hold at that moment: the rise is on a byte boundary, at least one byte was received, the write-enable latch is set and the write-protect pin is high. The cycle is self-timed and lasts `PROG_CYCLES` clocks, with `busy_o` high throughout.

In its first four clocks the engine visits the slots in ascending order and writes each valid slot to the byte array. A slot is skipped when the neighbouring protection logic flags its address. No erase step comes first. In the last busy clock `done_o` pulses, which the neighbouring latch uses to return the device to the write-disabled state.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset `busy_o`, `arr_we_o` and `done_o` are all 0.
- R2: The data byte with index k after a start at address A lands in slot (A[1:0]+k) mod 4. It is written at array address {A[8:2], slot}, so bits [8:2] never change within a page.
- R3: When more than four bytes arrive, the slot pointer wraps and the later byte replaces the earlier one in that slot. Only the last value of each slot is programmed.
- R4: Only slots that received a byte are written. In a program cycle slot s is written in busy cycle s (counted from 0), so the slots go out in ascending order, one per clock.
- R5: A program cycle starts only on a `cs_rise` pulse with `cs_rise_bnd`=1 and at least one byte received. Otherwise there is no busy period and no array write, and the engine returns to idle.
- R6: `busy_o` rises in the clock after the qualifying `cs_rise` and stays high for exactly `PROG_CYCLES` consecutive clocks.
- R7: `done_o` is high for exactly one clock per program cycle, in its last busy clock, and `busy_o` is low in the clock after it.
- R8: If `wel`=0 or `wp_n`=0 at the `cs_rise`, the write is ignored: no busy period and no array write.
- R9: A valid slot is not written when `prot_hit` is 1 for its address, as presented on `prot_addr`. Other slots of the same page are still written.
- R10: While busy, `start_vld`, `byte_vld` and `cs_rise` have no effect. The running cycle keeps its length and its data, and no second cycle follows.
- R11: `arr_we_o` is high only within the first four clocks of a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_vld | input | 1 | Write instruction decoded; load start address |
| start_addr | input | ADDR_W | Start byte address |
| byte_vld | input | 1 | One complete data byte received |
| byte_data | input | DATA_W | Received data byte |
| cs_rise | input | 1 | Chip select has risen (one-clock pulse) |
| cs_rise_bnd | input | 1 | The rise followed a complete byte exactly |
| wel | input | 1 | Write-enable latch state |
| wp_n | input | 1 | Write-protect pin, low protects |
| prot_hit | input | 1 | Address on `prot_addr` lies in the protected block |
| prot_addr | output | ADDR_W | Address being queried for protection |
| busy_o | output | 1 | Program cycle in progress |
| arr_we_o | output | 1 | Byte array write strobe |
| arr_addr_o | output | ADDR_W | Byte array write address |
| arr_wdata_o | output | DATA_W | Byte array write data |
| done_o | output | 1 | Program cycle ends; clear the write-enable latch |

## Verification
On every clock the assertions hold several rules. A busy period may begin only after a boundary-qualified chip-select rise with the latch set and the protect pin high. Busy holds until the done pulse and drops right after it. The cycle counter stays in range, and a start clears the slot mask. Only the bench's scenarios can show the rest. The slot each byte lands in and the wrap-over replacement need a data check. The exact busy length, the busy cycle in which each slot is written, the per-level protection skip, and the ignoring of traffic sent during a busy period are observed against an arithmetic model over swept start slots, byte counts, base addresses and protection levels.

// File: rtl/eeprom_page_prog_pkg.sv
`timescale 1ns/1ps
package eeprom_page_prog_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_FILL = 2'd1,
        PG_PROG = 2'd2
    } pg_state_e;

endpackage

// File: rtl/eeprom_page_buf.sv
`timescale 1ns/1ps
module eeprom_page_buf #(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 4,
    localparam int PTR_W     = $clog2(PAGE_BYTES),
    localparam int HI_W      = ADDR_W - PTR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [ADDR_W-1:0]     load_addr,
    input  logic                  push,
    input  logic [DATA_W-1:0]     push_data,
    input  logic [PTR_W-1:0]      rd_slot,
    output logic [HI_W-1:0]       base_o,
    output logic [PAGE_BYTES-1:0] mask_o,
    output logic [DATA_W-1:0]     rd_data_o
);

    typedef struct packed {
        logic [HI_W-1:0]                    base;
        logic [PTR_W-1:0]                   ptr;
        logic [PAGE_BYTES-1:0]              mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]  data;
    } buf_t;

    buf_t buf_d, buf_q;

    // Next state: a load opens a fresh page, a push fills the current slot
    // and steps only the in-page pointer (it wraps at the page size).
    always_comb begin
        buf_d = buf_q;
        if (load) begin
            buf_d.base = load_addr[ADDR_W-1:PTR_W];
            buf_d.ptr  = load_addr[PTR_W-1:0];
            buf_d.mask = '0;
        end else if (push) begin
            buf_d.data[buf_q.ptr] = push_data;
            buf_d.mask[buf_q.ptr] = 1'b1;
            buf_d.ptr             = buf_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign base_o    = buf_q.base;
    assign mask_o    = buf_q.mask;
    assign rd_data_o = buf_q.data[rd_slot];

    // A new page starts with no valid slots.
    assert_load_clears_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mask_o == '0));

    // A pushed byte always leaves at least one valid slot behind.
    assert_push_marks_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load) |=> ($countones(mask_o) != 0));

    // The page base is frozen between loads.
    assert_base_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_o));

endmodule

// File: rtl/eeprom_prog_timer.sv
`timescale 1ns/1ps
module eeprom_prog_timer #(
    parameter int CYCLES = 1250000,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_end;

    assign at_end = (tmr_q.cnt == CNT_W'(CYCLES - 1));

    // Count busy clocks from zero; restart at zero whenever idle.
    always_comb begin
        tmr_d = tmr_q;
        if (!run || at_end) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cnt_o  = tmr_q.cnt;
    assign last_o = run && at_end;

    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o < CNT_W'(CYCLES));

    assert_restart_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (cnt_o == '0));

endmodule

// File: rtl/eeprom_page_prog.sv
`timescale 1ns/1ps
module eeprom_page_prog
    import eeprom_page_prog_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int PROG_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              cs_rise_bnd,
    input  logic              wel,
    input  logic              wp_n,
    input  logic              prot_hit,
    output logic [ADDR_W-1:0] prot_addr,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic              done_o
);

    localparam int PTR_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - PTR_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        pg_state_e state;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  buf_load;
    logic                  buf_push;
    logic [PTR_W-1:0]      cur_slot;
    logic [HI_W-1:0]       page_base;
    logic [PAGE_BYTES-1:0] slot_mask;
    logic [DATA_W-1:0]     slot_data;
    logic [CNT_W-1:0]      tmr_cnt;
    logic                  tmr_last;
    logic                  busy;
    logic                  arm;
    logic                  in_window;

    assign busy     = (ctl_q.state == PG_PROG);
    assign buf_load = start_vld && !busy && !cs_rise;
    assign buf_push = byte_vld && (ctl_q.state == PG_FILL) && !start_vld && !cs_rise;
    assign arm      = (ctl_q.state == PG_FILL) && cs_rise && cs_rise_bnd
                      && (slot_mask != '0) && wel && wp_n;

    eeprom_page_buf #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) page_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .load_addr (start_addr),
        .push      (buf_push),
        .push_data (byte_data),
        .rd_slot   (cur_slot),
        .base_o    (page_base),
        .mask_o    (slot_mask),
        .rd_data_o (slot_data)
    );

    eeprom_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .cnt_o  (tmr_cnt),
        .last_o (tmr_last)
    );

    // Control: collect after a start, arm on a qualified CS rise,
    // release when the self-timed cycle has run its full length.
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            PG_IDLE: begin
                if (start_vld && !cs_rise) ctl_d.state = PG_FILL;
            end
            PG_FILL: begin
                if (cs_rise) ctl_d.state = arm ? PG_PROG : PG_IDLE;
            end
            PG_PROG: begin
                if (tmr_last) ctl_d.state = PG_IDLE;
            end
            default: ctl_d.state = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: PG_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Commit phase: busy clock s visits slot s.
    assign cur_slot  = tmr_cnt[PTR_W-1:0];
    assign in_window = (tmr_cnt < CNT_W'(PAGE_BYTES));
    assign prot_addr = {page_base, cur_slot};

    assign arr_we_o    = busy && in_window && slot_mask[cur_slot] && !prot_hit;
    assign arr_addr_o  = {page_base, cur_slot};
    assign arr_wdata_o = slot_data;
    assign busy_o      = busy;
    assign done_o      = tmr_last;

    assert_busy_needs_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_rise && cs_rise_bnd));

    assert_busy_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wel && wp_n));

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_done_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_page_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(slot_mask));

endmodule

// File: tb/eeprom_page_prog_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_prog_tb_top;

    localparam int P = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_vld, byte_vld, cs_rise, cs_rise_bnd, wel, wp_n, prot_hit;
    logic [8:0] start_addr, prot_addr, arr_addr_o;
    logic [7:0] byte_data, arr_wdata_o;
    logic       busy_o, arr_we_o, done_o;

    int level;
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    function automatic logic prot_model(int lv, logic [8:0] a);
        case (lv)
            0:       return 1'b0;
            1:       return a >= 9'h180;
            2:       return a >= 9'h100;
            default: return 1'b1;
        endcase
    endfunction

    assign prot_hit = prot_model(level, prot_addr);

    eeprom_page_prog #(
        .ADDR_W (9), .DATA_W (8), .PAGE_BYTES (4), .PROG_CYCLES (P)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_vld (start_vld), .start_addr (start_addr),
        .byte_vld (byte_vld), .byte_data (byte_data), .cs_rise (cs_rise),
        .cs_rise_bnd (cs_rise_bnd), .wel (wel), .wp_n (wp_n), .prot_hit (prot_hit),
        .prot_addr (prot_addr), .busy_o (busy_o), .arr_we_o (arr_we_o),
        .arr_addr_o (arr_addr_o), .arr_wdata_o (arr_wdata_o), .done_o (done_o)
    );

    // Monitor, sampled away from the active edge.
    int         log_n, busy_n, done_n, bad_done, late_we;
    logic [8:0] log_a [0:15];
    logic [7:0] log_d [0:15];
    int         log_t [0:15];

    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we_o) begin
                if (log_n < 16) begin
                    log_a[log_n] = arr_addr_o;
                    log_d[log_n] = arr_wdata_o;
                    log_t[log_n] = busy_n;
                end
                if (!busy_o || busy_n >= 4) late_we++;
                log_n++;
            end
            if (busy_o) busy_n++;
            if (done_o) begin
                done_n++;
                if (!busy_o) bad_done++;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(logic [8:0] base, int k);
        return 8'(base[7:0] * 3 + k * 29 + 8'h5A);
    endfunction

    // One write instruction; compares against an arithmetic model.
    task automatic run_case(logic [8:0] base, int n, bit bnd, bit w, bit p,
                            int lv, bit intrude, string req);
        logic [7:0] exp_d [0:3];
        bit         exp_m [0:3];
        logic [1:0] ptr;
        bit         go;
        int         exp_n;
        for (int s = 0; s < 4; s++) begin exp_m[s] = 0; exp_d[s] = '0; end
        ptr = base[1:0];
        for (int k = 0; k < n; k++) begin
            exp_d[ptr] = dat(base, k);
            exp_m[ptr] = 1;
            ptr = ptr + 2'd1;
        end
        go = bnd && (n > 0) && w && p;

        @(negedge clk);
        #1;
        level = lv; wel = w; wp_n = p;
        log_n = 0; busy_n = 0; done_n = 0; bad_done = 0; late_we = 0;
        @(negedge clk);
        start_vld = 1; start_addr = base;
        @(negedge clk);
        start_vld = 0;
        for (int k = 0; k < n; k++) begin
            byte_vld = 1; byte_data = dat(base, k);
            @(negedge clk);
            byte_vld = 0;
        end
        cs_rise = 1; cs_rise_bnd = bnd;
        @(negedge clk);
        cs_rise = 0; cs_rise_bnd = 0;
        if (intrude) begin
            start_vld = 1; start_addr = base ^ 9'h1F4;
            @(negedge clk);
            start_vld = 0; byte_vld = 1; byte_data = 8'hE7;
            @(negedge clk);
            byte_vld = 0; cs_rise = 1; cs_rise_bnd = 1;
            @(negedge clk);
            cs_rise = 0; cs_rise_bnd = 0;
        end
        repeat (P + 4) @(negedge clk);
        #1;

        check(busy_n == (go ? P : 0), {req, " busy length R6"}, busy_n, go ? P : 0);
        check(done_n == (go ? 1 : 0) && bad_done == 0, {req, " done pulse R7"}, done_n, go ? 1 : 0);
        check(late_we == 0, {req, " write window R11"}, late_we, 0);
        exp_n = 0;
        for (int s = 0; s < 4; s++) begin
            logic [8:0] a;
            a = {base[8:2], 2'(s)};
            if (go && exp_m[s] && !prot_model(lv, a)) begin
                if (exp_n < log_n && exp_n < 16) begin
                    check(log_a[exp_n] == a, {req, " address R2"}, log_a[exp_n], a);
                    check(log_d[exp_n] == exp_d[s], {req, " data R3"}, log_d[exp_n], exp_d[s]);
                    check(log_t[exp_n] == s, {req, " slot order R4"}, log_t[exp_n], s);
                end
                exp_n++;
            end
        end
        check(log_n == exp_n, {req, " write count R4 R9"}, log_n, exp_n);
    endtask

    initial begin
        rst_n = 0; start_vld = 0; byte_vld = 0; cs_rise = 0; cs_rise_bnd = 0;
        wel = 1; wp_n = 1; level = 0; start_addr = '0; byte_data = '0;
        log_n = 0; busy_n = 0; done_n = 0; bad_done = 0; late_we = 0;
        repeat (3) @(negedge clk);
        check(busy_o == 0 && arr_we_o == 0 && done_o == 0, "R1 reset outputs",
              {busy_o, arr_we_o, done_o}, 0);
        rst_n = 1;
        @(negedge clk);
        check(busy_o == 0 && arr_we_o == 0 && done_o == 0, "R1 after release",
              {busy_o, arr_we_o, done_o}, 0);

        // R2 R3 R4 R5: every start slot with 0..6 bytes
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n <= 6; n++) begin
                run_case({7'(s * 19 + n * 5 + 3), 2'(s)}, n, 1, 1, 1, 0, 0, "R2/R3 sweep");
            end
        end
        // R5: rise off a byte boundary
        for (int n = 1; n <= 4; n++) run_case(9'h0A1, n, 0, 1, 1, 0, 0, "R5 no boundary");
        // R8: latch clear or pin low
        run_case(9'h042, 3, 1, 0, 1, 0, 0, "R8 latch clear");
        run_case(9'h042, 3, 1, 1, 0, 0, 0, "R8 protect pin");
        run_case(9'h042, 3, 1, 0, 0, 0, 0, "R8 both");
        // R9: protection levels across pages in each region
        for (int lv = 0; lv < 4; lv++) begin
            run_case(9'h0FD, 4, 1, 1, 1, lv, 0, "R9 low page");
            run_case(9'h17E, 4, 1, 1, 1, lv, 0, "R9 mid page");
            run_case(9'h1FC, 3, 1, 1, 1, lv, 0, "R9 top page");
        end
        // R10: traffic during busy is ignored, then a normal write works
        run_case(9'h133, 2, 1, 1, 1, 0, 1, "R10 busy traffic");
        run_case(9'h058, 4, 1, 1, 1, 0, 0, "R10 follow-up");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule